// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a cycle-accurate, synthesizable model of a synchronous burst static RAM. It stores 36-bit words split into four 9-bit byte lanes, and its depth is set by a small address-width parameter. On every rising clock edge it samples the address, two chip enables, two burst-start strobes, a burst-advance input and the write controls. A new address can be loaded on any cycle. A burst can also continue from a 2-bit internal counter that steps through the four words of an aligned group, in either linear or interleaved order.

A static mode input chooses between flow-through reads, where data comes straight out of the array, and pipelined reads, where data passes through one more output register. Deselect takes effect on the first edge after the last read beat. Output enable and sleep act on the outputs at once, without waiting for a clock. While sleep is sampled high, the block ignores every command and keeps its stored data and its burst position.

Top module: `burst_sram`

## Requirements
- R1: During reset and after its release with no command, `rvalid` is 0 and `rdata` is all zeros.
- R2: A start strobe (`start_cpu` or `start_ctl`) with both `ce_a` and `ce_b` high loads `addr` and accesses it. A `start_cpu` access is always a read and ignores the write controls. A `start_ctl` access writes when the write controls ask for a write and reads otherwise.
- R3: With no strobe during an active burst, the block accesses the next beat when `adv` is 1. When `adv` is 0 it repeats the access to the same word.
- R4: With `linear_mode`=1, beat n accesses low address bits (base[1:0]+n) mod 4, and the upper address bits stay fixed.
- R5: With `linear_mode`=0, beat n accesses low address bits base[1:0] XOR n, and the upper address bits stay fixed.
- R6: With `pipe_mode`=0, a read sampled at edge k drives `rvalid`=1 and the word on `rdata` from edge k until edge k+1.
- R7: With `pipe_mode`=1, a read sampled at edge k drives its word from edge k+1 until edge k+2. Until then the outputs show the previous slot.
- R8: With `byte_wr_en`=1, only the lanes whose `byte_sel` bit is set are written. Lane i is bits 9i+8 down to 9i. If `byte_wr_en`=0, or if no select bit is set, nothing is written and the access is a read.
- R9: `all_wr`=1 writes all four lanes, whatever `byte_wr_en` and `byte_sel` are.
- R10: A strobe sampled while either enable is low ends the burst. `rvalid` then drops one edge after the last read beat would have been shown: at the next edge in flow-through mode and one edge later in pipelined mode. `adv` has no effect until a new load.
- R11: Output enable `oe`=0 forces `rvalid` to 0 and `rdata` to zero at once. Raising `oe` brings the held data back.
- R12: `sleep`=1 forces the outputs off at once. Commands sampled during sleep are ignored, and the memory contents and burst position are kept.
- R13: Loading a new address on every cycle gives one read result per cycle, with no added wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| addr | input | ADDR_W | Word address loaded by a start strobe |
| ce_a | input | 1 | Chip enable A, active high |
| ce_b | input | 1 | Chip enable B, active high |
| start_cpu | input | 1 | Processor-side burst start, read only |
| start_ctl | input | 1 | Controller-side burst start, read or write |
| adv | input | 1 | Burst advance |
| byte_wr_en | input | 1 | Byte-write enable |
| byte_sel | input | LANES | Per-lane write select |
| all_wr | input | 1 | Global write of all lanes |
| wdata | input | LANES*LANE_W | Write data |
| linear_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through |
| oe | input | 1 | Output enable, acts without a clock |
| sleep | input | 1 | Sleep, acts on outputs without a clock |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid (outputs driven) |

## Verification
If the burst counter or the loaded base goes wrong, the next beat returns the wrong word. In flow-through mode this shows on `rdata` at the edge right after the beat is sampled, and in pipelined mode one edge later. The sequences check wrap-around in both orders so that an adder-for-XOR mix-up shows up within four beats. A bad output-valid stage shows as `rvalid` appearing one cycle early or late, or lingering after deselect. A bad write mask shows only when the word is read back, so every partial or suppressed write is followed by a read of the same word.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    // Low address bits of a burst beat for the selected order.
    function automatic beat_t beat_offset(beat_t base, beat_t cnt, logic lin);
        beat_t r;
        if (lin) r = base + cnt;
        else     r = base ^ cnt;
        return r;
    endfunction

endpackage

// File: rtl/bsr_addr_gen.sv
module bsr_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_a,
    input  logic              ce_b,
    input  logic              start_cpu,
    input  logic              start_ctl,
    input  logic              adv,
    input  logic              byte_wr_en,
    input  logic [LANES-1:0]  byte_sel,
    input  logic              all_wr,
    input  logic              linear_mode,
    input  logic              sleep,
    output logic              acc_vld,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_mask
);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] base;
        beat_t             cnt;
    } gen_st_t;

    gen_st_t st_d, st_q;

    logic             strobe;
    logic             chip_sel;
    logic [LANES-1:0] req_mask;

    always_comb begin
        strobe   = start_cpu | start_ctl;
        chip_sel = ce_a & ce_b;
        req_mask = all_wr ? {LANES{1'b1}} : (byte_wr_en ? byte_sel : '0);

        st_d     = st_q;
        acc_vld  = 1'b0;
        acc_addr = st_q.base;
        acc_mask = '0;

        if (!sleep) begin
            if (strobe) begin
                if (chip_sel) begin
                    st_d.active = 1'b1;
                    st_d.base   = addr;
                    st_d.cnt    = '0;
                    acc_vld     = 1'b1;
                    acc_addr    = addr;
                    acc_mask    = start_cpu ? '0 : req_mask;
                end else begin
                    st_d.active = 1'b0;
                end
            end else if (st_q.active) begin
                st_d.cnt = st_q.cnt + {{(BEAT_W-1){1'b0}}, adv};
                acc_vld  = 1'b1;
                acc_addr = {st_q.base[ADDR_W-1:BEAT_W],
                            beat_offset(st_q.base[BEAT_W-1:0], st_d.cnt, linear_mode)};
                acc_mask = req_mask;
            end
        end
    end

    assign acc_wr = |acc_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    deselect_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && strobe && !chip_sel) |=> !st_q.active);

    // R12
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(st_q));

    // R9
    global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && all_wr && !start_cpu) |-> (acc_mask == {LANES{1'b1}}));

    // R2
    cpu_strobe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && start_cpu && chip_sel) |-> (acc_vld && !acc_wr));

    // R3
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strobe && st_q.active && !adv && $past(acc_vld)
         && $stable(linear_mode)) |-> (acc_addr == $past(acc_addr)));

endmodule

// File: rtl/bsr_mem_array.sv
module bsr_mem_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we_mask,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_mask[g]) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/bsr_out_stage.sv
module bsr_out_stage #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_data,
    input  logic              pipe_mode,
    input  logic              oe,
    input  logic              sleep,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic              fvld;
        logic [ADDR_W-1:0] raddr;
        logic              pvld;
        logic [WORD_W-1:0] pdata;
    } out_st_t;

    out_st_t st_d, st_q;

    logic              sel_vld;
    logic [WORD_W-1:0] sel_data;

    always_comb begin
        st_d       = st_q;
        st_d.fvld  = rd_en;
        st_d.raddr = rd_en ? rd_addr : st_q.raddr;
        st_d.pvld  = st_q.fvld;
        st_d.pdata = mem_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr = st_q.raddr;

    always_comb begin
        sel_vld  = pipe_mode ? st_q.pvld  : st_q.fvld;
        sel_data = pipe_mode ? st_q.pdata : mem_data;
        rvalid   = sel_vld & oe & ~sleep;
        rdata    = rvalid ? sel_data : '0;
    end

    // R6
    flow_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && rvalid) |-> $past(rd_en));

    // R7
    pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && rvalid) |-> $past(rd_en, 2));

    // R7
    pipe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && rvalid) |-> (rdata == $past(mem_data)));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce_a,
    input  logic                    ce_b,
    input  logic                    start_cpu,
    input  logic                    start_ctl,
    input  logic                    adv,
    input  logic                    byte_wr_en,
    input  logic [LANES-1:0]        byte_sel,
    input  logic                    all_wr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    linear_mode,
    input  logic                    pipe_mode,
    input  logic                    oe,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int WORD_W = LANES * LANE_W;

    logic              acc_vld;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_mask;
    logic [ADDR_W-1:0] mem_raddr;
    logic [WORD_W-1:0] mem_rdata;
    logic              rd_en;

    bsr_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .ce_a        (ce_a),
        .ce_b        (ce_b),
        .start_cpu   (start_cpu),
        .start_ctl   (start_ctl),
        .adv         (adv),
        .byte_wr_en  (byte_wr_en),
        .byte_sel    (byte_sel),
        .all_wr      (all_wr),
        .linear_mode (linear_mode),
        .sleep       (sleep),
        .acc_vld     (acc_vld),
        .acc_wr      (acc_wr),
        .acc_addr    (acc_addr),
        .acc_mask    (acc_mask)
    );

    assign rd_en = acc_vld & ~acc_wr;

    bsr_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .we_mask (acc_mask),
        .waddr   (acc_addr),
        .wdata   (wdata),
        .raddr   (mem_raddr),
        .rdata   (mem_rdata)
    );

    bsr_out_stage #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (acc_addr),
        .mem_addr  (mem_raddr),
        .mem_data  (mem_rdata),
        .pipe_mode (pipe_mode),
        .oe        (oe),
        .sleep     (sleep),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;

    localparam int AW    = 6;
    localparam int LN    = 4;
    localparam int LW    = 9;
    localparam int W     = LN * LW;
    localparam int DEPTH = 1 << AW;
    localparam logic [W:0] OFF = '0;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_a, ce_b, start_cpu, start_ctl, adv;
    logic          byte_wr_en, all_wr;
    logic [LN-1:0] byte_sel;
    logic [W-1:0]  wdata;
    logic          linear_mode, pipe_mode, oe, sleep;
    logic [W-1:0]  rdata;
    logic          rvalid;

    burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_a(ce_a), .ce_b(ce_b),
        .start_cpu(start_cpu), .start_ctl(start_ctl), .adv(adv),
        .byte_wr_en(byte_wr_en), .byte_sel(byte_sel), .all_wr(all_wr),
        .wdata(wdata), .linear_mode(linear_mode), .pipe_mode(pipe_mode),
        .oe(oe), .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
    );

    logic [W-1:0] ref_mem [DEPTH];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(string req, logic [W:0] exp);
        logic [W:0] act;
        act = {rvalid, rdata};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W:0] hit(int a);
        return {1'b1, ref_mem[a]};
    endfunction

    function automatic logic [W-1:0] merge(logic [W-1:0] old_w, logic [W-1:0] new_w,
                                           logic [LN-1:0] m);
        logic [W-1:0] r;
        r = old_w;
        for (int i = 0; i < LN; i++)
            if (m[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
        return r;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        start_cpu = 0; start_ctl = 0; adv = 0; byte_wr_en = 0;
        byte_sel = '0; all_wr = 0; ce_a = 1; ce_b = 1;
    endtask

    task automatic wr_global(int a, logic [W-1:0] d);
        idle(); start_ctl = 1; addr = AW'(a); all_wr = 1; wdata = d;
        step(); ref_mem[a] = d; idle();
    endtask

    task automatic load(int a, bit cpu);
        idle(); addr = AW'(a);
        if (cpu) start_cpu = 1; else start_ctl = 1;
        step(); idle();
    endtask

    task automatic deselect_b();
        idle(); start_ctl = 1; ce_b = 0; step(); idle();
    endtask

    task automatic t_reset();
        rst_n = 0; idle(); addr = '0; wdata = '0;
        linear_mode = 1; pipe_mode = 0; oe = 1; sleep = 0;
        repeat (3) step();
        chk("R1 in reset", OFF);
        rst_n = 1; step();
        chk("R1 after reset", OFF);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 32; i++)
            wr_global(i, W'(64'(i + 1) * 64'h0000_0009_C3A1_7B5D));
        deselect_b();
        chk("R10 idle after fill", OFF);
    endtask

    task automatic t_linear_flow();
        linear_mode = 1; pipe_mode = 0;
        load(5, 1'b1);          chk("R6 first beat base 5", hit(5));
        adv = 1; step();        chk("R4 beat1 addr 6", hit(6));
        step();                 chk("R4 beat2 addr 7", hit(7));
        step();                 chk("R4 beat3 wraps to 4", hit(4));
        adv = 0; step();        chk("R3 adv low repeats 4", hit(4));
        idle(); start_ctl = 1; ce_a = 0; step(); idle();
        chk("R10 flow off after deselect", OFF);
        adv = 1; step(); adv = 0;
        chk("R10 adv ignored after deselect", OFF);
    endtask

    task automatic t_inter_pipe();
        linear_mode = 0; pipe_mode = 1;
        load(6, 1'b1);          chk("R7 nothing yet after load", OFF);
        adv = 1; step();        chk("R7 beat0 addr 6", hit(6));
        step();                 chk("R5 beat1 addr 7", hit(7));
        step();                 chk("R5 beat2 addr 4", hit(4));
        idle(); start_ctl = 1; ce_b = 0; step(); idle();
        chk("R5 beat3 addr 5 shown at deselect", hit(5));
        step();                 chk("R10 pipe off one edge later", OFF);
        pipe_mode = 0;
        load(11, 1'b1);         chk("R5 flow base 11", hit(11));
        adv = 1; step();        chk("R5 flow beat1 addr 10", hit(10));
        step();                 chk("R5 flow beat2 addr 9", hit(9));
        adv = 0; deselect_b();
        linear_mode = 1;
    endtask

    task automatic t_bytes();
        logic [W-1:0] nd;
        pipe_mode = 0;
        wr_global(12, {W{1'b1}});
        nd = 36'h0_1234_5678;
        idle(); start_ctl = 1; addr = 12; byte_wr_en = 1; byte_sel = 4'b0101; wdata = nd;
        step(); idle();
        ref_mem[12] = merge(ref_mem[12], nd, 4'b0101);
        load(12, 1'b1);         chk("R8 lanes 0 and 2 written", hit(12));
        idle(); start_ctl = 1; addr = 12; byte_sel = 4'b1111; wdata = '0;
        step(); idle();         chk("R8 byte_sel without enable reads", hit(12));
        idle(); start_ctl = 1; addr = 12; byte_wr_en = 1; byte_sel = '0; wdata = '0;
        step(); idle();         chk("R8 enable without select reads", hit(12));
        idle(); start_ctl = 1; addr = 12; all_wr = 1; byte_wr_en = 1;
        byte_sel = 4'b0001; wdata = 36'h9_8765_4321;
        step(); idle(); ref_mem[12] = 36'h9_8765_4321;
        load(12, 1'b1);         chk("R9 global overrides byte select", hit(12));
        idle(); start_ctl = 1; addr = 16; all_wr = 1; wdata = 36'hA_AAAA_0001;
        step(); ref_mem[16] = wdata;
        start_ctl = 0; adv = 1; wdata = 36'hB_BBBB_0002;
        step(); ref_mem[17] = wdata;
        wdata = 36'hC_CCCC_0003;
        step(); ref_mem[18] = wdata; idle();
        load(17, 1'b1);         chk("R3 burst write beat1 at 17", hit(17));
        load(18, 1'b1);         chk("R3 burst write beat2 at 18", hit(18));
        deselect_b();
    endtask

    task automatic t_cpu_read();
        pipe_mode = 0;
        idle(); start_cpu = 1; addr = 20; all_wr = 1; wdata = '0;
        step(); idle();         chk("R2 cpu strobe ignores write", hit(20));
        load(20, 1'b0);         chk("R2 ctl strobe read back unchanged", hit(20));
        deselect_b();
    endtask

    task automatic t_b2b();
        int seq [4] = '{3, 9, 1, 30};
        pipe_mode = 0;
        foreach (seq[i]) begin
            load(seq[i], 1'b1);
            chk("R13 flow new address each cycle", hit(seq[i]));
        end
        deselect_b();
        pipe_mode = 1;
        load(2, 1'b1);
        load(8, 1'b1);          chk("R13 pipe word 2", hit(2));
        load(15, 1'b1);         chk("R13 pipe word 8", hit(8));
        deselect_b();           chk("R13 pipe word 15", hit(15));
        step();
        pipe_mode = 0;
    endtask

    task automatic t_oe_sleep();
        load(7, 1'b1);          chk("R11 baseline read 7", hit(7));
        #1 oe = 0;
        #0.5 chk("R11 oe low turns outputs off", OFF);
        oe = 1;
        #0.5 chk("R11 oe high restores data", hit(7));
        sleep = 1;
        #0.5 chk("R12 sleep turns outputs off", OFF);
        step();
        idle(); start_ctl = 1; addr = 7; all_wr = 1; wdata = '0;
        step(); idle(); adv = 1;
        step(); adv = 0;        chk("R12 outputs off during sleep", OFF);
        sleep = 0;
        step();                 chk("R12 contents and burst kept", hit(7));
        deselect_b();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1-all actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fill();
        t_linear_flow();
        t_inter_pipe();
        t_bytes();
        t_cpu_read();
        t_b2b();
        t_oe_sleep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule